// File: doc/BRIEF.md
# Frame-Sequence Colour Dither Engine

This block turns 3:3:2 indexed pixels into three on/off sub-pixel bits for a passive LCD panel. A passive panel can only switch a sub-pixel fully on or fully off. Intermediate shades are therefore built over time: each sub-pixel is switched on in a fraction of successive frames. The fraction is chosen per colour channel through small programmable level-to-code tables. The on/off sequence behind each fraction comes from programmable pattern registers.

Each cycle the caller presents a pixel byte with a valid strobe, the current frame count and the pixel's column and line. One cycle later the block returns the three sub-pixel bits. The column and line are added into the sequence position, so neighbouring pixels step through their patterns out of phase. A greyscale mode sends the 2-bit level through the blue table to all three outputs. Fetching pixels and packing the bits onto the panel bus are left to neighbouring blocks.

Top module: `tdither_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `outValid` and `subPix` are 0. Reset loads the default tables of R10 and the default patterns of R5.
- R2: The pixel byte splits into red level = bits 7:5, green level = bits 4:2 and blue level = bits 1:0. The output bits are `subPix[2]` red, `subPix[1]` green and `subPix[0]` blue.
- R3: The 4-bit duty codes are:
  - 0 = always off and 15 = always on, at any frame, column or line.
  - 1..6 = 1/7..6/7.
  - 7 = 1/5, 8 = 2/5, 9 = 3/5, 10 = 4/5.
  - 11 = 2/4, 12 = 3/4.
  - 13 = 1/3, 14 = 2/3.
- R4: Writing `cfgData` with `cfgWe` at `cfgAddr` 0, 1 or 2 loads the red, green or blue table. Red and green take level n from bits 4n+3:4n. Blue uses only bits 15:0, with level n at bits 4n+3:4n.
- R5: The pattern registers sit at the following addresses, with the given reset values:

  | Address | Pattern(s) | Bits | Reset value |
  |---|---|---|---|
  | 3 | 2/3 | 2:0 | 3'b011 |
  | 4 | 3/4 | 19:16 | 4'b0111 |
  | 4 | 2/4 | 3:0 | 4'b0101 |
  | 5 | 4/5 | 4:0 | 5'b01111 |
  | 6 | 3/5 | 4:0 | 5'b01011 |
  | 7 | 6/7 | 6:0 | 7'b0111111 |
  | 8 | 5/7 | 6:0 | 7'b0110111 |
  | 9 | 4/7 | 6:0 | 7'b0101011 |

  The codes 1/3, 1/5, 2/5, 1/7, 2/7 and 3/7 output the inverted bit of 2/3, 4/5, 3/5, 6/7, 5/7 and 4/7 respectively.
- R6: For a pattern of length L (3, 4, 5 or 7), the output is pattern bit number (frameCnt + pixCol + pixLine) mod L.
- R7: With `greyMode` high, all three outputs use the blue table indexed by pixel bits 1:0.
- R8: `outValid` and `subPix` are registered one cycle after `pixValid`. When `pixValid` is low, the next `subPix` is 0.
- R9: A write to addresses 10..15 changes nothing. A pixel presented in the same cycle as a write uses the old table, and the new content applies from the next cycle.
- R10: The default red and green tables map levels 0..7 to 0, 2/7, 2/5, 2/4, 3/5, 5/7, 4/5 and 1, which is 32'hFA59B820. The default blue table maps levels 0..3 to 0, 1/3, 5/7 and 1, which is 16'hF5D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgData | input | 32 | Configuration write data |
| greyMode | input | 1 | 2-bit greyscale mode select |
| pixValid | input | 1 | Pixel valid strobe |
| pixData | input | 8 | 3:3:2 pixel byte |
| frameCnt | input | FRAME_W | Frame counter |
| pixCol | input | COL_W | Pixel column |
| pixLine | input | LINE_W | Pixel line |
| outValid | output | 1 | Output valid |
| subPix | output | 3 | Red, green, blue sub-pixel bits |

## Verification
The bench first sweeps all 256 pixel values against the default tables, which separates errors in the red, green and blue field split from errors in the output bit order. Frame-only, column-only and line-only walks with a fixed pixel show whether each position term enters the modulo sum. Per-level frame sweeps count the on frames over one pattern length, so a wrong numerator or a swapped complement shows up as a count mismatch. Reprogrammed tables covering all sixteen codes, random pattern contents, writes to unused addresses, and greyscale pixels interleaved with invalid cycles separate table decoding, pattern selection and invert pairing from the valid gating.

// File: rtl/dither_pkg.sv
package dither_pkg;
  localparam int NREG   = 10;
  localparam int ADDR_W = 4;

  typedef struct packed {
    logic [NREG-1:0] wrSel;
    logic            capture;
  } ctl_t;

  localparam logic [31:0] LUT_RG_RST = 32'hFA59B820;
  localparam logic [15:0] LUT_B_RST  = 16'hF5D0;
  localparam logic [2:0]  PAT23_RST  = 3'b011;
  localparam logic [3:0]  PAT34_RST  = 4'b0111;
  localparam logic [3:0]  PAT24_RST  = 4'b0101;
  localparam logic [4:0]  PAT45_RST  = 5'b01111;
  localparam logic [4:0]  PAT35_RST  = 5'b01011;
  localparam logic [6:0]  PAT67_RST  = 7'b0111111;
  localparam logic [6:0]  PAT57_RST  = 7'b0110111;
  localparam logic [6:0]  PAT47_RST  = 7'b0101011;
endpackage

// File: rtl/dither_ctrl.sv
module dither_ctrl
  import dither_pkg::*;
(
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              pixValid,
  output ctl_t              ctl
);
  logic [NREG-1:0] wrVec;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign wrVec[i] = cfgWe && (cfgAddr == ADDR_W'(i));
    end
  endgenerate

  assign ctl = '{wrSel: wrVec, capture: pixValid};
endmodule

// File: rtl/dither_datapath.sv
module dither_datapath
  import dither_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int COL_W   = 10,
  parameter int LINE_W  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               ctl,
  input  logic [31:0]        cfgData,
  input  logic               greyMode,
  input  logic [7:0]         pixData,
  input  logic [FRAME_W-1:0] frameCnt,
  input  logic [COL_W-1:0]   pixCol,
  input  logic [LINE_W-1:0]  pixLine,
  output logic               outValid,
  output logic [2:0]         subPix
);
  localparam int MAXW  = (FRAME_W > COL_W) ? ((FRAME_W > LINE_W) ? FRAME_W : LINE_W)
                                           : ((COL_W > LINE_W) ? COL_W : LINE_W);
  localparam int SUM_W = MAXW + 2;

  logic [31:0] lutR, lutG;
  logic [15:0] lutB;
  logic [2:0]  p23;
  logic [3:0]  p34, p24;
  logic [4:0]  p45, p35;
  logic [6:0]  p67, p57, p47;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lutR <= LUT_RG_RST; lutG <= LUT_RG_RST; lutB <= LUT_B_RST;
      p23 <= PAT23_RST; p34 <= PAT34_RST; p24 <= PAT24_RST;
      p45 <= PAT45_RST; p35 <= PAT35_RST;
      p67 <= PAT67_RST; p57 <= PAT57_RST; p47 <= PAT47_RST;
    end else begin
      if (ctl.wrSel[0]) lutR <= cfgData;
      if (ctl.wrSel[1]) lutG <= cfgData;
      if (ctl.wrSel[2]) lutB <= cfgData[15:0];
      if (ctl.wrSel[3]) p23 <= cfgData[2:0];
      if (ctl.wrSel[4]) begin
        p34 <= cfgData[19:16];
        p24 <= cfgData[3:0];
      end
      if (ctl.wrSel[5]) p45 <= cfgData[4:0];
      if (ctl.wrSel[6]) p35 <= cfgData[4:0];
      if (ctl.wrSel[7]) p67 <= cfgData[6:0];
      if (ctl.wrSel[8]) p57 <= cfgData[6:0];
      if (ctl.wrSel[9]) p47 <= cfgData[6:0];
    end
  end

  // sequence position, offset by screen location
  logic [SUM_W-1:0] phaseSum;
  logic [1:0] ph3, ph4;
  logic [2:0] ph5, ph7;
  assign phaseSum = SUM_W'(frameCnt) + SUM_W'(pixCol) + SUM_W'(pixLine);
  assign ph3 = 2'(phaseSum % SUM_W'(3));
  assign ph4 = phaseSum[1:0];
  assign ph5 = 3'(phaseSum % SUM_W'(5));
  assign ph7 = 3'(phaseSum % SUM_W'(7));

  function automatic logic codeBit(input logic [3:0] c);
    case (c)
      4'd0:    return 1'b0;
      4'd1:    return ~p67[ph7];
      4'd2:    return ~p57[ph7];
      4'd3:    return ~p47[ph7];
      4'd4:    return p47[ph7];
      4'd5:    return p57[ph7];
      4'd6:    return p67[ph7];
      4'd7:    return ~p45[ph5];
      4'd8:    return ~p35[ph5];
      4'd9:    return p35[ph5];
      4'd10:   return p45[ph5];
      4'd11:   return p24[ph4];
      4'd12:   return p34[ph4];
      4'd13:   return ~p23[ph3];
      4'd14:   return p23[ph3];
      default: return 1'b1;
    endcase
  endfunction

  // channel 0 blue, 1 green, 2 red
  logic [3:0] code [3];
  logic [2:0] nextBits;

  generate
    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      if (ch == 0) begin : g_blue
        assign code[0] = lutB[{pixData[1:0], 2'b00} +: 4];
      end else begin : g_rg
        logic [2:0]  lvl;
        logic [31:0] tab;
        assign lvl = pixData[3*ch+1 -: 3];
        assign tab = (ch == 1) ? lutG : lutR;
        assign code[ch] = greyMode ? code[0] : tab[{lvl, 2'b00} +: 4];
      end
      assign nextBits[ch] = codeBit(code[ch]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      subPix   <= 3'b000;
    end else begin
      outValid <= ctl.capture;
      subPix   <= ctl.capture ? nextBits : 3'b000;
    end
  end

  assert_capture_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> outValid);
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> (!outValid && subPix == 3'b000));
  assert_code_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && code[2] == 4'hF) |=> subPix[2]);
  assert_code_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && code[2] == 4'h0) |=> !subPix[2]);
  assert_lut_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrSel[0] |=> $stable(lutR));
endmodule

// File: rtl/tdither_engine.sv
module tdither_engine
  import dither_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int COL_W   = 10,
  parameter int LINE_W  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [3:0]         cfgAddr,
  input  logic [31:0]        cfgData,
  input  logic               greyMode,
  input  logic               pixValid,
  input  logic [7:0]         pixData,
  input  logic [FRAME_W-1:0] frameCnt,
  input  logic [COL_W-1:0]   pixCol,
  input  logic [LINE_W-1:0]  pixLine,
  output logic               outValid,
  output logic [2:0]         subPix
);
  ctl_t ctl;

  dither_ctrl u_ctrl (
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .pixValid(pixValid), .ctl(ctl)
  );

  dither_datapath #(.FRAME_W(FRAME_W), .COL_W(COL_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgData(cfgData), .greyMode(greyMode),
    .pixData(pixData), .frameCnt(frameCnt), .pixCol(pixCol), .pixLine(pixLine),
    .outValid(outValid), .subPix(subPix)
  );
endmodule

// File: tb/sim_tdither_engine.sv
`timescale 1ns/1ps
module sim_tdither_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        greyMode = 1'b0;
  logic        pixValid = 1'b0;
  logic [7:0]  pixData = '0;
  logic [7:0]  frameCnt = '0;
  logic [9:0]  pixCol = '0;
  logic [8:0]  pixLine = '0;
  logic        outValid;
  logic [2:0]  subPix;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit cmpOn = 0;

  always #5 clk = ~clk;

  tdither_engine u0 (.*);

  // behavioural reference state
  logic [31:0] mReg [10];
  logic        expValid;
  logic [2:0]  expPix;

  task automatic modelReset();
    mReg[0] = 32'hFA59B820; mReg[1] = 32'hFA59B820; mReg[2] = 32'h0000F5D0;
    mReg[3] = 32'h3;        mReg[4] = 32'h00070005; mReg[5] = 32'h0F;
    mReg[6] = 32'h0B;       mReg[7] = 32'h3F;       mReg[8] = 32'h37;
    mReg[9] = 32'h2B;
  endtask

  function automatic bit modelBit(int c, int s);
    case (c)
      0:  return 0;
      15: return 1;
      1, 6: return (c == 6) ? mReg[7][s % 7] : !mReg[7][s % 7];
      2, 5: return (c == 5) ? mReg[8][s % 7] : !mReg[8][s % 7];
      3, 4: return (c == 4) ? mReg[9][s % 7] : !mReg[9][s % 7];
      7, 10: return (c == 10) ? mReg[5][s % 5] : !mReg[5][s % 5];
      8, 9: return (c == 9) ? mReg[6][s % 5] : !mReg[6][s % 5];
      11: return mReg[4][s % 4];
      12: return mReg[4][16 + (s % 4)];
      13: return !mReg[3][s % 3];
      default: return mReg[3][s % 3];
    endcase
  endfunction

  function automatic logic [2:0] modelPix();
    int s = int'(frameCnt) + int'(pixCol) + int'(pixLine);
    int lv [3];
    int tb [3];
    logic [2:0] r;
    if (greyMode) begin
      for (int k = 0; k < 3; k++) begin lv[k] = int'(pixData[1:0]); tb[k] = 2; end
    end else begin
      lv[2] = int'(pixData[7:5]); tb[2] = 0;
      lv[1] = int'(pixData[4:2]); tb[1] = 1;
      lv[0] = int'(pixData[1:0]); tb[0] = 2;
    end
    for (int k = 0; k < 3; k++)
      r[k] = modelBit(int'((mReg[tb[k]] >> (4 * lv[k])) & 32'hF), s);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      expValid = 0; expPix = 0; modelReset();
    end else begin
      expValid = pixValid;
      expPix = pixValid ? modelPix() : 3'b000;
      if (cfgWe && cfgAddr < 4'd10) mReg[cfgAddr] = cfgData;
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      checks++;
      if (outValid !== expValid || subPix !== expPix) begin
        errors++;
        $display("FAIL %s: actual valid=%b pix=%b expected valid=%b pix=%b",
                 curReq, outValid, subPix, expValid, expPix);
      end
    end
  end

  task automatic stepPix(input logic [7:0] px, input logic [7:0] fr,
                         input logic [9:0] c, input logic [8:0] l, input logic v);
    @(negedge clk);
    cfgWe = 0; pixData = px; frameCnt = fr; pixCol = c; pixLine = l; pixValid = v;
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1; cfgAddr = a; cfgData = d;
    pixValid = 1'($urandom); pixData = 8'($urandom); frameCnt = 8'($urandom);
  endtask

  task automatic randomPix(input int n);
    for (int k = 0; k < n; k++)
      stepPix(8'($urandom), 8'($urandom), 10'($urandom), 9'($urandom), 1'($urandom % 4 != 0));
  endtask

  // R10: count on-frames of the red sub-pixel over one pattern length
  task automatic dutyCheck(input int lvl, input int len, input int num);
    int ones = 0;
    for (int f = 0; f < len; f++) begin
      stepPix({3'(lvl), 5'b0}, 8'(f), 10'd0, 9'd0, 1'b1);
      @(posedge clk); #1;
      ones += int'(subPix[2]);
    end
    checks++;
    if (ones != num) begin
      errors++;
      $display("FAIL R10: level %0d on-frames actual %0d expected %0d of %0d", lvl, ones, num, len);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8: watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset
    @(posedge clk); #1 cmpOn = 1;
    repeat (3) @(negedge clk);
    stepPix(8'hFF, 8'd0, 10'd0, 9'd0, 1'b1);
    rstN = 1;
    stepPix(8'hFF, 8'd0, 10'd0, 9'd0, 1'b0);

    // R10: default mapping fractions
    curReq = "R10";
    dutyCheck(0, 7, 0); dutyCheck(1, 7, 2); dutyCheck(2, 5, 2); dutyCheck(3, 4, 2);
    dutyCheck(4, 5, 3); dutyCheck(5, 7, 5); dutyCheck(6, 5, 4); dutyCheck(7, 7, 7);

    // R2: every pixel value
    curReq = "R2";
    for (int p = 0; p < 256; p++)
      for (int f = 0; f < 3; f++)
        stepPix(8'(p), 8'(f * 2 + p), 10'(p * 3), 9'(p), 1'b1);

    // R6: each position term alone
    curReq = "R6";
    for (int k = 0; k < 40; k++) stepPix(8'h6D, 8'(k), 10'd0, 9'd0, 1'b1);
    for (int k = 0; k < 40; k++) stepPix(8'h6D, 8'd0, 10'(k * 37), 9'd0, 1'b1);
    for (int k = 0; k < 40; k++) stepPix(8'h6D, 8'd0, 10'd0, 9'(k * 13), 1'b1);
    stepPix(8'hB6, 8'hFF, 10'h3FF, 9'h1FF, 1'b1);

    // R8: valid gating
    curReq = "R8";
    for (int k = 0; k < 60; k++)
      stepPix(8'hFF, 8'($urandom), 10'($urandom), 9'($urandom), 1'(k % 3 == 0));

    // R4 and R3: all sixteen codes through the tables
    curReq = "R4";
    cfgWrite(4'd0, 32'h76543210);
    cfgWrite(4'd1, 32'hFEDCBA98);
    cfgWrite(4'd2, 32'h1234C7E1);
    randomPix(400);
    curReq = "R3";
    cfgWrite(4'd0, 32'hF0F0F0F0);
    for (int k = 0; k < 40; k++) stepPix(8'(k * 32), 8'($urandom), 10'($urandom), 9'($urandom), 1'b1);

    // R5: random pattern contents
    curReq = "R5";
    cfgWrite(4'd0, 32'hDCBA9876);
    cfgWrite(4'd1, 32'h54321EED);
    for (int r = 0; r < 4; r++) begin
      for (int a = 3; a < 10; a++) cfgWrite(4'(a), $urandom);
      randomPix(150);
    end

    // R9: unused addresses and same-cycle writes
    curReq = "R9";
    for (int a = 10; a < 16; a++) begin
      cfgWrite(4'(a), $urandom);
      randomPix(10);
    end
    for (int k = 0; k < 30; k++) begin
      cfgWrite(4'($urandom % 10), $urandom);
      randomPix(2);
    end

    // R7: greyscale mode
    curReq = "R7";
    cfgWrite(4'd2, 32'h0000F5D0);
    greyMode = 1;
    randomPix(300);
    greyMode = 0;
    randomPix(20);

    stepPix(8'h00, 8'd0, 10'd0, 9'd0, 1'b0);
    @(negedge clk);
    #1 cmpOn = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule